// File: doc/BRIEF.md
# Serial Flash Array Read Slave

This block is the read side of a paged serial flash. It behaves as an SPI mode-0 target: while chip select is low it takes one command bit on every rising serial clock, decodes an 8-bit command, collects a 24-bit address and a 32-bit dummy field, and then streams bytes from its main array, most significant bit first. The serial pins are sampled in the `clk_i` domain. The system clock must run at least four times faster than the serial clock. The output is a data bit plus an enable. The enable being low stands for a released (high-impedance) pin.

It has two read commands, and they differ only in how the read address moves past the last byte of a page. A continuous read goes on into the next page and wraps from the last page back to page 0. A page read stays inside the page it started in. The array holds `PAGES` pages of `PAGE_BYTES` bytes each. It is a behavioural memory with a byte-wide preload port for simulation.

Top module: `sflash_rd_slave`

## Requirements
- R1: After reset, and on every clock after chip select has been high for two consecutive clocks, `so_en_o` is 0.
- R2: Commands 0x68 and 0xE8 select continuous read, and 0x52 and 0xD2 select page read. After the 8 command bits, 24 address bits and 32 dummy bits, the next serial clock falling edge drives bit 7 of the addressed byte on `so_o`. Each later falling edge drives the next lower bit, and each byte follows the previous one.
- R3: The address is sent MSB first. Bits 23..19 are reserved and ignored. Bits 18..9 are the page field, of which only the low log2(`PAGES`) bits are used (`PAGES` is a power of two). Bits 8..0 are the starting byte within the page.
- R4: In continuous read, the byte after byte `PAGE_BYTES`-1 is byte 0 of the next page, with no idle bit between them.
- R5: In continuous read, the byte after the last byte of page `PAGES`-1 is byte 0 of page 0.
- R6: In page read, the byte after byte `PAGE_BYTES`-1 is byte 0 of the same page.
- R7: A starting byte field of `PAGE_BYTES` or more starts the read at byte 0 of the addressed page.
- R8: Any other command value keeps `so_en_o` at 0 for the rest of that chip-select-low period, whatever is clocked in afterwards.
- R9: Chip select going high at any point, even in the middle of a data byte, drops `so_en_o` within two clocks. The next low period starts a fresh command decode.
- R10: `so_en_o` stays 0 during the command, address and dummy phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, samples the serial pins |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock, idles low |
| cs_ni | input | 1 | Chip select, active low |
| si_i | input | 1 | Serial data in |
| so_o | output | 1 | Serial data out |
| so_en_o | output | 1 | Output drive enable; 0 means released |
| pre_we_i | input | 1 | Preload write strobe |
| pre_addr_i | input | IDX_W | Preload byte index, page*PAGE_BYTES+byte |
| pre_data_i | input | 8 | Preload byte |

## Verification
The array is filled with a value that depends on both page and byte, so a wrong page and a wrong byte give different results. Reads are started in the middle of a page, two bytes before a page end, two bytes before the array end and at an out-of-range byte index. Both codes of each command are used. Comparing a page-end read under the two commands shows whether the wrap rule follows the command. An undefined command followed by a long clock train, and an abort partway through a byte followed by a new read, show that chip select alone controls the output enable and the decoder restart.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  typedef enum logic [2:0] {ST_OPC, ST_ADR, ST_DUM, ST_DATA, ST_BAD} rd_state_e;
  typedef enum logic {MODE_CONT, MODE_PAGE} rd_mode_e;

  localparam logic [7:0] OP_CONT_A = 8'h68;
  localparam logic [7:0] OP_CONT_B = 8'hE8;
  localparam logic [7:0] OP_PAGE_A = 8'h52;
  localparam logic [7:0] OP_PAGE_B = 8'hD2;

  localparam int OPC_BITS = 8;
  localparam int ADR_BITS = 24;
  localparam int DUM_BITS = 32;
  localparam int BY_W     = 9;
endpackage

// File: rtl/sfr_edge.sv
module sfr_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic cs_ni,
  output logic rise_o,
  output logic fall_o
);
  logic sck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_q <= 1'b0;
    else         sck_q <= sck_i;
  end

  assign rise_o = sck_i & ~sck_q & ~cs_ni;
  assign fall_o = ~sck_i & sck_q & ~cs_ni;
endmodule

// File: rtl/sfr_addr_step.sv
module sfr_addr_step #(
  parameter int PAGES      = 8,
  parameter int PAGE_BYTES = 264,
  parameter int PG_W       = $clog2(PAGES),
  parameter int BY_W       = 9
) (
  input  logic             [PG_W-1:0] page_i,
  input  logic             [BY_W-1:0] byte_i,
  input  sfr_pkg::rd_mode_e           mode_i,
  output logic             [PG_W-1:0] page_o,
  output logic             [BY_W-1:0] byte_o
);
  logic last_byte, last_page;

  assign last_byte = (byte_i == BY_W'(PAGE_BYTES - 1));
  assign last_page = (page_i == PG_W'(PAGES - 1));

  always_comb begin
    page_o = page_i;
    byte_o = byte_i + 1'b1;
    if (last_byte) begin
      byte_o = '0;
      if (mode_i == sfr_pkg::MODE_CONT)
        page_o = last_page ? '0 : page_i + 1'b1;
    end
  end
endmodule

// File: rtl/sfr_array.sv
module sfr_array #(
  parameter int DEPTH = 2112,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  logic [7:0]       wdata_i,
  input  logic [IDX_W-1:0] raddr_i,
  output logic [7:0]       rdata_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/sflash_rd_slave.sv
module sflash_rd_slave #(
  parameter int PAGES      = 8,
  parameter int PAGE_BYTES = 264,
  localparam int PG_W      = $clog2(PAGES),
  localparam int DEPTH     = PAGES * PAGE_BYTES,
  localparam int IDX_W     = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sck_i,
  input  logic             cs_ni,
  input  logic             si_i,
  output logic             so_o,
  output logic             so_en_o,
  input  logic             pre_we_i,
  input  logic [IDX_W-1:0] pre_addr_i,
  input  logic [7:0]       pre_data_i
);
  import sfr_pkg::*;

  localparam int CNT_W = $clog2(DUM_BITS);
  localparam int SH_W  = 8 + PG_W;

  rd_state_e        state;
  rd_mode_e         mode;
  logic [CNT_W-1:0] bit_cnt;
  logic [SH_W-1:0]  shift;
  logic [PG_W-1:0]  cur_page, nxt_page;
  logic [BY_W-1:0]  cur_byte, nxt_byte, in_byte;
  logic [2:0]       obit;
  logic             so_q, en_q;
  logic             sck_rise, sck_fall;
  logic [7:0]       rd_byte, opc_word;
  logic [IDX_W-1:0] rd_idx;

  sfr_edge u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sck_i (sck_i),
    .cs_ni (cs_ni),
    .rise_o(sck_rise),
    .fall_o(sck_fall)
  );

  sfr_addr_step #(
    .PAGES(PAGES), .PAGE_BYTES(PAGE_BYTES), .PG_W(PG_W), .BY_W(BY_W)
  ) u_step (
    .page_i(cur_page),
    .byte_i(cur_byte),
    .mode_i(mode),
    .page_o(nxt_page),
    .byte_o(nxt_byte)
  );

  assign rd_idx = IDX_W'(cur_page) * IDX_W'(PAGE_BYTES) + IDX_W'(cur_byte);

  sfr_array #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_array (
    .clk_i  (clk_i),
    .we_i   (pre_we_i),
    .waddr_i(pre_addr_i),
    .wdata_i(pre_data_i),
    .raddr_i(rd_idx),
    .rdata_o(rd_byte)
  );

  assign opc_word = {shift[6:0], si_i};
  assign in_byte  = {shift[7:0], si_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state    <= ST_OPC;
      mode     <= MODE_CONT;
      bit_cnt  <= '0;
      shift    <= '0;
      cur_page <= '0;
      cur_byte <= '0;
      obit     <= '0;
      so_q     <= 1'b0;
      en_q     <= 1'b0;
    end else if (cs_ni) begin
      state   <= ST_OPC;
      bit_cnt <= '0;
      obit    <= '0;
      so_q    <= 1'b0;
      en_q    <= 1'b0;
    end else begin
      if (sck_rise) begin
        shift <= {shift[SH_W-2:0], si_i};
        unique case (state)
          ST_OPC: begin
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == CNT_W'(OPC_BITS - 1)) begin
              bit_cnt <= '0;
              unique case (opc_word)
                OP_CONT_A, OP_CONT_B: begin mode <= MODE_CONT; state <= ST_ADR; end
                OP_PAGE_A, OP_PAGE_B: begin mode <= MODE_PAGE; state <= ST_ADR; end
                default:              state <= ST_BAD;
              endcase
            end
          end
          ST_ADR: begin
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == CNT_W'(ADR_BITS - 1)) begin
              bit_cnt  <= '0;
              cur_page <= shift[8 +: PG_W];
              cur_byte <= (in_byte >= BY_W'(PAGE_BYTES)) ? '0 : in_byte;
              state    <= ST_DUM;
            end
          end
          ST_DUM: begin
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == CNT_W'(DUM_BITS - 1)) begin
              bit_cnt <= '0;
              obit    <= '0;
              state   <= ST_DATA;
            end
          end
          default: ;
        endcase
      end
      // data bits launch on the falling edge; the address steps with the last bit of a byte
      if (sck_fall && state == ST_DATA) begin
        so_q <= rd_byte[3'd7 - obit];
        en_q <= 1'b1;
        obit <= obit + 1'b1;
        if (obit == 3'd7) begin
          cur_page <= nxt_page;
          cur_byte <= nxt_byte;
        end
      end
    end
  end

  assign so_o    = so_q;
  assign so_en_o = en_q;
endmodule

// File: rtl/sfr_checker.sv
module sfr_checker #(
  parameter int PAGES      = 8,
  parameter int PAGE_BYTES = 264,
  localparam int PG_W      = $clog2(PAGES)
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                cs_ni,
  input logic                so_en_o,
  input sfr_pkg::rd_state_e  state_i,
  input sfr_pkg::rd_mode_e   mode_i,
  input logic [PG_W-1:0]     cur_page_i,
  input logic [8:0]          cur_byte_i
);
  import sfr_pkg::*;

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni && $past(cs_ni) |-> !so_en_o);

  assert_hdr_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    so_en_o |-> state_i == ST_DATA);

  assert_bad_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == ST_BAD |-> !so_en_o);

  assert_page_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == ST_DATA && $past(state_i) == ST_DATA && mode_i == MODE_PAGE
    |-> $stable(cur_page_i));

  assert_cont_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == ST_DATA && $past(state_i) == ST_DATA && mode_i == MODE_CONT
    && !$stable(cur_page_i) |-> cur_byte_i == 9'd0);

  assert_byte_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == ST_DATA |-> cur_byte_i < 9'(PAGE_BYTES));
endmodule

bind sflash_rd_slave sfr_checker #(.PAGES(PAGES), .PAGE_BYTES(PAGE_BYTES)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cs_ni     (cs_ni),
  .so_en_o   (so_en_o),
  .state_i   (state),
  .mode_i    (mode),
  .cur_page_i(cur_page),
  .cur_byte_i(cur_byte)
);

// File: tb/tb_sflash_rd_slave.sv
`timescale 1ns/1ps
module tb_sflash_rd_slave;
  localparam int PAGES = 8;
  localparam int PB    = 264;
  localparam int DEPTH = PAGES * PB;
  localparam int IDX_W = $clog2(DEPTH);

  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, si = 1'b0;
  logic pre_we = 1'b0;
  logic [IDX_W-1:0] pre_addr = '0;
  logic [7:0] pre_data = '0;
  logic so, so_en;

  always #2.5 clk = ~clk;

  sflash_rd_slave #(.PAGES(PAGES), .PAGE_BYTES(PB)) dut (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .cs_ni(cs_n), .si_i(si),
    .so_o(so), .so_en_o(so_en),
    .pre_we_i(pre_we), .pre_addr_i(pre_addr), .pre_data_i(pre_data)
  );

  int n_run = 0, n_fail = 0;
  bit done = 0;
  bit mon_on = 0;
  bit en_seen = 0;
  int mcnt = 0;
  logic [7:0] mbyte = '0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  function automatic logic [7:0] pat(int p, int b);
    return 8'(((b * 3) ^ (p * 29)) + 17);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic half();
    repeat (4) @(negedge clk);
  endtask

  // one serial bit: falling edge, data set, half period, rising edge, half period
  task automatic clk_bit(logic b);
    sck = 1'b0;
    si  = b;
    half();
    if (so_en) en_seen = 1'b1;
    sck = 1'b1;
    half();
  endtask

  task automatic send_hdr(logic [7:0] op, logic [4:0] rsv, logic [9:0] pg, logic [8:0] by);
    logic [23:0] adr;
    adr = {rsv, pg, by};
    en_seen = 1'b0;
    @(negedge clk);
    cs_n = 1'b0;
    half();
    for (int i = 7; i >= 0; i--) clk_bit(op[i]);
    for (int i = 23; i >= 0; i--) clk_bit(adr[i]);
    for (int i = 0; i < 32; i++) clk_bit(1'b0);
  endtask

  task automatic end_cs(string tag);
    sck = 1'b0;
    half();
    cs_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(so_en == 1'b0, tag, so_en, 0);
  endtask

  // driver: pushes expected bytes, then clocks the data phase for the monitor
  task automatic read_cmd(logic [7:0] op, logic [4:0] rsv, logic [9:0] pg, logic [8:0] by,
                          int n, string tag);
    int p, b;
    bit page_mode;
    page_mode = (op == 8'h52) || (op == 8'hD2);
    p = pg % PAGES;
    b = (by >= PB) ? 0 : by;
    for (int k = 0; k < n; k++) begin
      exp_q.push_back(pat(p, b));
      tag_q.push_back(tag);
      if (b == PB - 1) begin
        b = 0;
        if (!page_mode) p = (p + 1) % PAGES;
      end else b++;
    end
    send_hdr(op, rsv, pg, by);
    chk(!en_seen, "R10", en_seen, 0);
    mcnt = 0;
    mon_on = 1'b1;
    for (int k = 0; k < n * 8; k++) clk_bit(1'b0);
    mon_on = 1'b0;
    chk(exp_q.size() == 0, tag, exp_q.size(), 0);
    exp_q.delete();
    tag_q.delete();
    end_cs("R1");
  endtask

  // monitor: takes so at each rising edge of the data phase, compares per byte
  always @(posedge sck) begin
    if (mon_on) begin
      logic [7:0] nb;
      nb = {mbyte[6:0], so};
      mbyte = nb;
      mcnt++;
      if (mcnt == 8) begin
        mcnt = 0;
        if (exp_q.size() == 0) chk(1'b0, "scoreboard", nb, 0);
        else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(nb == e && so_en, t, {so_en, nb}, {1'b1, e});
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(so_en == 1'b0, "R1", so_en, 0);

    for (int p = 0; p < PAGES; p++)
      for (int b = 0; b < PB; b++) begin
        @(negedge clk);
        pre_we   = 1'b1;
        pre_addr = IDX_W'(p * PB + b);
        pre_data = pat(p, b);
      end
    @(negedge clk);
    pre_we = 1'b0;
    repeat (4) @(negedge clk);

    // R2 R3: mid-page start, reserved bits set and unused page bits set
    read_cmd(8'h68, 5'h1F, 10'h3FA, 9'd10, 4, "R2");
    read_cmd(8'hD2, 5'h00, 10'd1, 9'd100, 3, "R3");
    // R4: continuous read across a page end
    read_cmd(8'hE8, 5'h00, 10'd3, 9'd262, 4, "R4");
    // R5: continuous read across the array end
    read_cmd(8'h68, 5'h0A, 10'd7, 9'd262, 4, "R5");
    // R6: page read wraps inside its page
    read_cmd(8'h52, 5'h00, 10'd5, 9'd261, 5, "R6");
    read_cmd(8'hD2, 5'h00, 10'd7, 9'd263, 3, "R6");
    // R7: byte index out of range
    read_cmd(8'hD2, 5'h00, 10'd4, 9'd300, 2, "R7");
    read_cmd(8'h68, 5'h00, 10'd2, 9'd511, 2, "R7");

    // R8: undefined command, long clock train
    en_seen = 1'b0;
    @(negedge clk);
    cs_n = 1'b0;
    half();
    for (int i = 7; i >= 0; i--) clk_bit(8'h11 >> i);
    for (int i = 0; i < 96; i++) clk_bit(i[0]);
    chk(!en_seen, "R8", en_seen, 0);
    end_cs("R8");

    // R9: abort in the middle of a data byte, then a fresh command
    send_hdr(8'h68, 5'h00, 10'd1, 9'd5);
    for (int i = 0; i < 3; i++) clk_bit(1'b0);
    chk(so_en == 1'b1, "R9", so_en, 1);
    cs_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(so_en == 1'b0, "R9", so_en, 0);
    sck = 1'b0;
    half();
    read_cmd(8'h52, 5'h00, 10'd6, 9'd0, 2, "R9");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule